// File: doc/BRIEF.md
# Banked GPIO Controller with Atomic Set/Clear Access

This block drives and samples 128 general-purpose pins grouped into four ports of 32 bits. Pin n sits in port n/32 at bit n mod 32. Software never rewrites a whole output word. It changes output levels and pin directions through write-one-to-set and write-one-to-clear addresses, so one bus write can change any group of bits in a port without a read-modify-write sequence.

Ports 0 and 1 each own a direction register. Ports 2 and 3 share a single direction register: bit k of it enables the output driver of bit k on both ports. Input pins pass through a synchronizer and can be read per port. The output latch and the direction state can be read back at their own read-only addresses.

The register bus is single-cycle. An address, write data and a write strobe are sampled on a rising edge. Read data is registered and shows the word for the address presented in the previous cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every output enable is 0, every output latch bit is 0, and the read data is 0.
- R2: Writing to a port's output-set address (offset 0) sets each latch bit written as 1. Bits written as 0 keep their value. The latch appears on the port's output pins and at its latch read-back address (offset 2).
- R3: Writing to a port's output-clear address (offset 1) clears each latch bit written as 1. Bits written as 0 keep their value.
- R4: Ports 0 and 1 each have their own direction-set address (offset 4), direction-clear address (offset 5) and direction read-back address (offset 6). A 1 makes a pin an output, and a 0 leaves that bit unchanged. A write to one port's direction has no effect on the other port.
- R5: The direction register at port 2's direction offsets is shared: bit k drives the output enable of bit k on both port 2 and port 3.
- R6: A direction write never changes any output latch bit.
- R7: The pin-state address (offset 3) of a port returns that port's pin levels after a two-flop synchronizer. A pin change applied before rising edge e appears in read data sampled after edge e+2.
- R8: Read data is registered. The word for the address present at a rising edge appears after that edge and not before.
- R9: Reads of set or clear addresses (offsets 0, 1, 4 and 5) return 0.
- R10: Offset 7 of any port, port 3's direction offsets, and any port index of 4 or more are unmapped. Writes there change no latch or direction bit, and reads there return 0.
- R11: With no write, output pins and output enables hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Word address: port index in the upper bits, register offset in the low 3 bits |
| bus_wdata | input | PORT_W (32) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | PORT_W (32) | Registered read data |
| pin_in | input | 128 | Pin levels sampled from the pads |
| pin_out | output | 128 | Output latch driven to the pads |
| pin_oe | output | 128 | Output enable per pin |

## Verification
Set and clear writes use masks with mixed ones and zeros across several ports, so a wrong mask polarity, a whole-word overwrite or a port decode that lands on the wrong port gives a different read-back word. Direction writes go to port 0, port 1, the shared group and port 3's unmapped direction slot. This tells true sharing apart from aliasing or independent registers. It also checks that the latch is untouched by direction writes. Distinct patterns on each port's pins, and a step on one port, separate the synchronizer delay from the registered-read delay. Writes to unmapped slots followed by read-back confirm that nothing outside the map leaks into state.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_OUT_SET = 3'd0;
  localparam logic [OFF_W-1:0] OFF_OUT_CLR = 3'd1;
  localparam logic [OFF_W-1:0] OFF_OUT_RD  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_PIN_RD  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_DIR_SET = 3'd4;
  localparam logic [OFF_W-1:0] OFF_DIR_CLR = 3'd5;
  localparam logic [OFF_W-1:0] OFF_DIR_RD  = 3'd6;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int DIR_GROUPS = 3,
  parameter int ADDR_W     = 6,
  localparam int PIDX_W    = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  output logic [PIDX_W-1:0]     pidx,
  output logic [OFF_W-1:0]      off,
  output logic [NUM_PORTS-1:0]  oset_en,
  output logic [NUM_PORTS-1:0]  oclr_en,
  output logic [DIR_GROUPS-1:0] dset_en,
  output logic [DIR_GROUPS-1:0] dclr_en
);
  assign pidx = addr[ADDR_W-1:OFF_W];
  assign off  = addr[OFF_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign oset_en[p] = we && (pidx == PIDX_W'(p)) && (off == OFF_OUT_SET);
    assign oclr_en[p] = we && (pidx == PIDX_W'(p)) && (off == OFF_OUT_CLR);
  end

  for (genvar g = 0; g < DIR_GROUPS; g++) begin : g_grp
    assign dset_en[g] = we && (pidx == PIDX_W'(g)) && (off == OFF_DIR_SET);
    assign dclr_en[g] = we && (pidx == PIDX_W'(g)) && (off == OFF_DIR_CLR);
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int PORT_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SHARED_FROM = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS   = NUM_PORTS * PORT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [PORT_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [PORT_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int DIR_GROUPS = (SHARED_FROM < NUM_PORTS) ? SHARED_FROM + 1 : NUM_PORTS;
  localparam int PIDX_W     = ADDR_W - OFF_W;

  logic [PIDX_W-1:0]     pidx;
  logic [OFF_W-1:0]      off;
  logic [NUM_PORTS-1:0]  oset_en, oclr_en;
  logic [DIR_GROUPS-1:0] dset_en, dclr_en;
  logic [PORT_W-1:0]     out_q  [NUM_PORTS];
  logic [PORT_W-1:0]     sync_q [NUM_PORTS];
  logic [PORT_W-1:0]     dir_q  [DIR_GROUPS];
  logic [PORT_W-1:0]     rd_next;

  gpio_bank_dec #(
    .NUM_PORTS (NUM_PORTS),
    .DIR_GROUPS(DIR_GROUPS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .pidx   (pidx),
    .off    (off),
    .oset_en(oset_en),
    .oclr_en(oclr_en),
    .dset_en(dset_en),
    .dclr_en(dclr_en)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int GRP = (p < SHARED_FROM) ? p : SHARED_FROM;

    gpio_setclr_reg #(.W(PORT_W)) u_out (
      .clk   (clk),
      .rst   (rst),
      .set_en(oset_en[p]),
      .clr_en(oclr_en[p]),
      .mask  (bus_wdata),
      .q     (out_q[p])
    );

    gpio_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (pin_in[p*PORT_W +: PORT_W]),
      .q  (sync_q[p])
    );

    assign pin_out[p*PORT_W +: PORT_W] = out_q[p];
    assign pin_oe[p*PORT_W +: PORT_W]  = dir_q[GRP];
  end

  for (genvar g = 0; g < DIR_GROUPS; g++) begin : g_dir
    gpio_setclr_reg #(.W(PORT_W)) u_dir (
      .clk   (clk),
      .rst   (rst),
      .set_en(dset_en[g]),
      .clr_en(dclr_en[g]),
      .mask  (bus_wdata),
      .q     (dir_q[g])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (pidx == PIDX_W'(p)) begin
        case (off)
          OFF_OUT_RD: rd_next = out_q[p];
          OFF_PIN_RD: rd_next = sync_q[p];
          default: ;
        endcase
      end
    end
    for (int g = 0; g < DIR_GROUPS; g++) begin
      if ((pidx == PIDX_W'(g)) && (off == OFF_DIR_RD)) rd_next = dir_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int PORT_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SHARED_FROM = 2,
  localparam int NUM_PINS   = NUM_PORTS * PORT_W,
  localparam int PIDX_W     = ADDR_W - OFF_W
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [PORT_W-1:0]   bus_wdata,
  input logic                bus_we,
  input logic [PORT_W-1:0]   bus_rdata,
  input logic [PORT_W-1:0]   pin_in0,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  localparam logic [ADDR_W-1:0] A_P0_SET = ADDR_W'({PIDX_W'(0), OFF_OUT_SET});
  localparam logic [ADDR_W-1:0] A_P0_CLR = ADDR_W'({PIDX_W'(0), OFF_OUT_CLR});
  localparam logic [ADDR_W-1:0] A_P0_PIN = ADDR_W'({PIDX_W'(0), OFF_PIN_RD});
  localparam logic [ADDR_W-1:0] A_SH_SET = ADDR_W'({PIDX_W'(SHARED_FROM), OFF_DIR_SET});

  logic [1:0]        cyc;
  logic [OFF_W-1:0]  off;
  logic [PIDX_W-1:0] pidx;
  assign off  = bus_addr[OFF_W-1:0];
  assign pidx = bus_addr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst)           cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && bus_rdata == '0));

  p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_P0_SET) |=>
      ((pin_out[PORT_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_P0_CLR) |=>
      ((pin_out[PORT_W-1:0] & $past(bus_wdata)) == '0));

  if (SHARED_FROM < NUM_PORTS) begin : g_shared
    p_shared_dir_r5: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_SH_SET) |=>
        (((pin_oe[SHARED_FROM*PORT_W +: PORT_W] & $past(bus_wdata)) == $past(bus_wdata)) &&
         ((pin_oe[(NUM_PORTS-1)*PORT_W +: PORT_W] & $past(bus_wdata)) == $past(bus_wdata))));
  end

  p_dir_keeps_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (off == OFF_DIR_SET || off == OFF_DIR_CLR)) |=> $stable(pin_out));

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3 && $past(bus_addr) == A_P0_PIN) |-> (bus_rdata == $past(pin_in0, 3)));

  p_wo_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (off == OFF_OUT_SET || off == OFF_OUT_CLR || off == OFF_DIR_SET || off == OFF_DIR_CLR)
      |=> (bus_rdata == '0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (off == 3'd7 || int'(pidx) >= NUM_PORTS) |=>
      ($stable(pin_out) && $stable(pin_oe) && bus_rdata == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .PORT_W     (PORT_W),
  .ADDR_W     (ADDR_W),
  .SHARED_FROM(SHARED_FROM)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_we   (bus_we),
  .bus_rdata(bus_rdata),
  .pin_in0  (pin_in[PORT_W-1:0]),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  // address = port*8 + offset
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd0,  32'hF0F0_00FF, 4'd2},
    '{1'b0, 6'd2,  32'hF0F0_00FF, 4'd2},   // R2
    '{1'b1, 6'd0,  32'h0000_0F00, 4'd2},
    '{1'b0, 6'd2,  32'hF0F0_0FFF, 4'd2},   // R2 zeros keep
    '{1'b1, 6'd1,  32'h0000_00F0, 4'd3},
    '{1'b0, 6'd2,  32'hF0F0_0F0F, 4'd3},   // R3
    '{1'b1, 6'd12, 32'h8000_0001, 4'd4},
    '{1'b0, 6'd14, 32'h8000_0001, 4'd4},   // R4
    '{1'b1, 6'd13, 32'h0000_0001, 4'd4},
    '{1'b0, 6'd14, 32'h8000_0000, 4'd4},   // R4
    '{1'b0, 6'd6,  32'h0000_0000, 4'd4},   // R4 port 0 untouched
    '{1'b1, 6'd20, 32'h0000_FFFF, 4'd5},
    '{1'b0, 6'd22, 32'h0000_FFFF, 4'd5},   // R5
    '{1'b1, 6'd28, 32'hFFFF_0000, 4'd10},  // R10 port 3 dir slot
    '{1'b0, 6'd22, 32'h0000_FFFF, 4'd10},
    '{1'b0, 6'd30, 32'h0000_0000, 4'd10},
    '{1'b0, 6'd0,  32'h0000_0000, 4'd9},   // R9
    '{1'b0, 6'd13, 32'h0000_0000, 4'd9},
    '{1'b1, 6'd24, 32'h1234_5678, 4'd2},
    '{1'b0, 6'd26, 32'h1234_5678, 4'd2},
    '{1'b0, 6'd7,  32'h0000_0000, 4'd10},
    '{1'b1, 6'd32, 32'hFFFF_FFFF, 4'd10},  // R10 port index 4
    '{1'b0, 6'd2,  32'hF0F0_0F0F, 4'd10},
    '{1'b0, 6'd19, 32'hCAFE_F00D, 4'd7}    // R7
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    pin_in = {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0123_4567, 32'h89AB_CDEF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pin_oe[31:0] | pin_oe[127:96], 32'h0, "R1 oe");
    chk(pin_out[31:0] | pin_out[127:96], 32'h0, "R1 out");
    chk(bus_rdata, 32'h0, "R1 rdata");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        chk(v, VECS[i].data, $sformatf("R%0d vec %0d", VECS[i].req, i));
      end
    end

    // R2 latch on pins, R5 shared enable, R4 port 1 enable
    chk(pin_out[31:0], 32'hF0F0_0F0F, "R2 pins");
    chk(pin_oe[95:64], 32'h0000_FFFF, "R5 port2 oe");
    chk(pin_oe[127:96], 32'h0000_FFFF, "R5 port3 oe");
    chk(pin_oe[63:32], 32'h8000_0000, "R4 port1 oe");
    rd(6'd3, v);
    chk(v, 32'h89AB_CDEF, "R7 port0 pins");

    // R6 direction writes keep the latch
    wr(6'd4, 32'hFFFF_FFFF);
    chk(pin_oe[31:0], 32'hFFFF_FFFF, "R6 oe set");
    chk(pin_out[31:0], 32'hF0F0_0F0F, "R6 latch after dir set");
    wr(6'd5, 32'hFFFF_FFFF);
    chk(pin_out[31:0], 32'hF0F0_0F0F, "R6 latch after dir clr");

    // R11 idle cycles hold outputs
    repeat (4) @(negedge clk);
    chk(pin_out[127:96], 32'h1234_5678, "R11 hold out");
    chk(pin_oe[95:64], 32'h0000_FFFF, "R11 hold oe");

    // R7 synchronizer timing and R8 registered read
    @(negedge clk);
    bus_addr = 6'd3;
    pin_in[31:0] = 32'h5555_AAAA;
    #1 chk(bus_rdata, 32'h0000_0000, "R8 no change before edge");
    @(negedge clk); chk(bus_rdata, 32'h89AB_CDEF, "R7 after edge 1");
    @(negedge clk); chk(bus_rdata, 32'h89AB_CDEF, "R7 after edge 2");
    @(negedge clk); chk(bus_rdata, 32'h5555_AAAA, "R7 after edge 3");

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(pin_out[31:0] | pin_out[127:96], 32'h0, "R1 out after reset");
    chk(pin_oe[95:64] | pin_oe[63:32], 32'h0, "R1 oe after reset");
    chk(bus_rdata, 32'h0, "R1 rdata after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule